// File: doc/BRIEF.md
# Bitfield Merge and Extract Unit

This execution unit for a 32-bit datapath performs two bitfield operations. Merge copies the source bits into the destination word at every position where a mask bit is set. All other destination bits are kept. Extract takes a contiguous run of bits out of the source word and returns it right-aligned and zero-filled. The bounds of the run come from one packed descriptor operand.

Each request carries an opcode, three 32-bit operands and a valid strobe. The unit registers the result, a valid flag and an error flag, so every request has a latency of one cycle. A new request can be accepted on every cycle without stalling. Extraction is built from a logarithmic right shifter that sits inside the unit's own datapath. A second copy of the same shifter builds the field mask.

Top module: `bitfield_unit`

## Requirements
- R1: With op_i = 0 (merge), each bit of result_o equals the src_i bit where the ctrl_i (mask) bit is 1, and the dest_i bit where it is 0.
- R2: Merging mask 0x0007FF00 and src 0xC5680CB2 into dest 0x1AF7C1E8 yields 0x1AF00CE8.
- R3: With op_i = 1 (extract), the upper index is ctrl_i[11:6] and the lower index is ctrl_i[5:0]. The result holds src_i[upper:lower] with src_i[lower] at bit 0.
- R4: For a legal extract, every result bit above position (upper − lower) is zero.
- R5: result_o, valid_o and error_o reflect the request presented on the previous rising clock edge. valid_o is 1 exactly when valid_i was 1 on that edge, and requests on consecutive cycles are each answered in turn.
- R6: For an extract whose upper index is below its lower index, or whose upper or lower index exceeds 31, result_o is 0 and error_o is 1 together with valid_o.
- R7: For extract, ctrl_i[31:12] and dest_i have no effect on the result.
- R8: A merge never raises error_o.
- R9: While rst_ni is low, valid_o, error_o and result_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 1 | 0 = merge, 1 = extract |
| dest_i | input | 32 | Destination word (merge) |
| src_i | input | 32 | Source word |
| ctrl_i | input | 32 | Mask (merge) or field descriptor (extract) |
| result_o | output | 32 | Registered result |
| valid_o | output | 1 | Result valid |
| error_o | output | 1 | Illegal extract descriptor |

## Verification
Some properties are checked on every cycle. The merge result is tested bit by bit against both operands. A legal extract must have zero bits above its field width. The valid flag must follow the strobe with one cycle of delay. An error must come with a zero result, and a merge must never raise an error. Other behaviours only the bench scenarios can show: that the field really lands at bit 0 with the right content, the reference merge value, the three kinds of illegal descriptor, the upper descriptor bits being ignored, and the reset state.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic {
    OP_MERGE   = 1'b0,
    OP_EXTRACT = 1'b1
  } bfu_op_e;
endpackage

// File: rtl/bfu_shr.sv
module bfu_shr #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [AW+1];
  assign stage[0] = data_i;

  // one mux level per shift-amount bit
  for (genvar s = 0; s < AW; s++) begin : g_stage
    assign stage[s+1] = amt_i[s] ? (stage[s] >> (1 << s)) : stage[s];
  end

  assign data_o = stage[AW];
endmodule

// File: rtl/bfu_merge.sv
module bfu_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0] dest_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] res_o
);
  assign res_o = (dest_i & ~mask_i) | (src_i & mask_i);

  always_comb begin
    // R1: masked bits from src, the rest from dest
    a_r1_merge_bits : assert ((((res_o ^ src_i) & mask_i) | ((res_o ^ dest_i) & ~mask_i)) == '0);
  end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int W = 32,
  localparam int AW = $clog2(W),
  localparam int FW = AW + 1
) (
  input  logic [W-1:0]    src_i,
  input  logic [2*FW-1:0] desc_i,
  output logic [W-1:0]    res_o,
  output logic            err_o
);
  logic [FW-1:0] hi, lo;
  logic [AW-1:0] diff;
  logic [W-1:0]  shifted, mask;
  logic [FW:0]   span;

  assign hi    = desc_i[2*FW-1:FW];
  assign lo    = desc_i[FW-1:0];
  assign err_o = hi[FW-1] | lo[FW-1] | (hi < lo);
  assign diff  = hi[AW-1:0] - lo[AW-1:0];

  bfu_shr #(.W(W)) u_data_shr (
    .data_i (src_i),
    .amt_i  (lo[AW-1:0]),
    .data_o (shifted)
  );

  // mask of diff+1 ones: all-ones shifted right by (W-1-diff)
  bfu_shr #(.W(W)) u_mask_shr (
    .data_i ({W{1'b1}}),
    .amt_i  (~diff),
    .data_o (mask)
  );

  assign res_o = err_o ? '0 : (shifted & mask);

  assign span = {1'b0, hi} - {1'b0, lo} + 1'b1;

  always_comb begin
    if (!err_o) begin
      // R4: nothing above the field width
      a_r4_upper_zero : assert ((res_o >> span) == '0);
    end
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int W = 32,
  localparam int AW = $clog2(W),
  localparam int FW = AW + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         op_i,
  input  logic [W-1:0] dest_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] ctrl_i,
  output logic [W-1:0] result_o,
  output logic         valid_o,
  output logic         error_o
);
  logic [W-1:0] mrg_res, ext_res;
  logic         ext_err, is_ext;
  logic [W-1:0] res_q;
  logic         valid_q, err_q;

  assign is_ext = (bfu_op_e'(op_i) == OP_EXTRACT);

  bfu_merge #(.W(W)) u_merge (
    .dest_i (dest_i),
    .src_i  (src_i),
    .mask_i (ctrl_i),
    .res_o  (mrg_res)
  );

  bfu_extract #(.W(W)) u_extract (
    .src_i  (src_i),
    .desc_i (ctrl_i[2*FW-1:0]),
    .res_o  (ext_res),
    .err_o  (ext_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      err_q   <= valid_i & is_ext & ext_err;
      if (valid_i) res_q <= is_ext ? ext_res : mrg_res;
    end
  end

  assign result_o = res_q;
  assign valid_o  = valid_q;
  assign error_o  = err_q;

  // R5: one-cycle valid latency
  a_r5_valid_follows : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r5_idle_follows : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R6: error comes with valid and a zero result
  a_r6_error_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (valid_o && result_o == '0));
  // R8: merge never flags an error
  a_r8_merge_no_err : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_ext) |=> !error_o);
endmodule

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        op_i = 1'b0;
  logic [31:0] dest_i = '0, src_i = '0, ctrl_i = '0;
  logic [31:0] result_o;
  logic        valid_o, error_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bitfield_unit u_dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .dest_i, .src_i, .ctrl_i,
    .result_o, .valid_o, .error_o
  );

  // extract descriptor: upper index in [11:6], lower in [5:0]
  localparam logic        V_OP   [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1};
  localparam logic [31:0] V_DEST [NV] = '{32'h1AF7C1E8, 32'h12345678, 32'h00000000, 32'h00000000,
                                          32'hFFFFFFFF, 32'h0, 32'h0, 32'hCAFEF00D,
                                          32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] V_SRC  [NV] = '{32'hC5680CB2, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'hFFFFFFFF,
                                          32'h000000A5, 32'hDEADBEEF, 32'h80000000, 32'h12345678,
                                          32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000003};
  localparam logic [31:0] V_CTRL [NV] = '{32'h0007FF00, 32'h00000000, 32'hFFFFFFFF, 32'hF0F0F0F0,
                                          32'h000001C4, 32'h000007C0, 32'h000007DF, 32'hFFFFF3C8,
                                          32'h000000C5, 32'h00000800, 32'h00000B68, 32'h00000000};
  localparam logic [31:0] V_RES  [NV] = '{32'h1AF00CE8, 32'h12345678, 32'hA5A5A5A5, 32'hF0F0F0F0,
                                          32'h0000000A, 32'hDEADBEEF, 32'h00000001, 32'h00000056,
                                          32'h0, 32'h0, 32'h0, 32'h00000001};
  localparam logic        V_ERR  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0};
  localparam string       V_TAG  [NV] = '{"R2", "R1", "R1", "R1/R8", "R3/R4", "R3", "R3/R4",
                                          "R7", "R6", "R6", "R6", "R3/R4"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk_i);
    chk("R9 valid", {31'b0, valid_o}, 32'h0);
    chk("R9 error", {31'b0, error_o}, 32'h0);
    chk("R9 result", result_o, 32'h0);
    rst_ni = 1'b1;

    // vector table, back to back (R5)
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk_i);
      if (i > 0) begin
        chk({V_TAG[i-1], " result"}, result_o, V_RES[i-1]);
        chk({V_TAG[i-1], " error"}, {31'b0, error_o}, {31'b0, V_ERR[i-1]});
        chk("R5 valid back-to-back", {31'b0, valid_o}, 32'h1);
      end
      if (i < NV) begin
        valid_i = 1'b1;
        op_i    = V_OP[i];
        dest_i  = V_DEST[i];
        src_i   = V_SRC[i];
        ctrl_i  = V_CTRL[i];
      end else begin
        valid_i = 1'b0;
      end
    end

    // R5: idle cycle drops valid
    @(negedge clk_i);
    chk("R5 idle valid", {31'b0, valid_o}, 32'h0);

    // R7: dest change alone does not alter extract (hi=15, lo=8)
    valid_i = 1'b1; op_i = 1'b1; src_i = 32'h12345678; ctrl_i = 32'h000003C8; dest_i = 32'h0;
    @(negedge clk_i);
    chk("R7 base", result_o, 32'h00000056);
    dest_i = 32'hFFFFFFFF; ctrl_i = 32'hABCDE3C8;
    @(negedge clk_i);
    chk("R7 dest/upper ignored", result_o, 32'h00000056);

    // R8: merge right after an error clears error_o
    op_i = 1'b1; ctrl_i = 32'h000000C5;
    @(negedge clk_i);
    chk("R6 err set", {31'b0, error_o}, 32'h1);
    op_i = 1'b0; dest_i = 32'h0; src_i = 32'h0000FFFF; ctrl_i = 32'h00FF00FF;
    @(negedge clk_i);
    chk("R8 no error", {31'b0, error_o}, 32'h0);
    chk("R1 merge", result_o, 32'h000000FF);

    // R9: asynchronous reset mid-stream
    valid_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    chk("R9 async valid", {31'b0, valid_o}, 32'h0);
    chk("R9 async result", result_o, 32'h0);
    finish_run();
  end
endmodule